// File: doc/BRIEF.md
# Wrap-Around Bit-Range Mask Builder and Merger

This unit serves two bit-field operations of a legacy integer pipe. In the first, it builds a 32-bit mask that is one from a start bit to a stop bit. Bits are counted from the most significant end, so index 0 is the MSB and index 31 is the LSB. When the start index lies beyond the stop index, the run of ones wraps past the LSB and continues at the MSB. In the second, it merges a source word into a destination word under a caller-supplied bit mask. Each bit of the merged word comes from the source where the mask is one and from the destination where it is zero.

The operand words enter together with a one-bit operation select and an input-valid strobe. The result is computed combinationally and captured in a single output register. The register raises an output-valid flag for exactly one cycle per accepted operation. Instruction decode, condition-flag update and the register file sit outside this block.

Top module: `mgi_unit`

## Requirements
- R1: Only the low five bits of `src_s` (start index) and of `src_b` (stop index) steer mask building; upper bits of both have no effect on the mask.
- R2: With `op_sel` = 0 and start < stop, result bit `31-i` is one exactly for MSB-first indices i from start to stop inclusive.
- R3: With `op_sel` = 0 and start = stop, exactly one result bit is set, at position `31-start`.
- R4: With `op_sel` = 0 and start > stop, the ones wrap: MSB-first indices from start to 31 and from 0 to stop are one, all others zero.
- R5: With `op_sel` = 0 and start = (stop + 1) mod 32, including start 0 with stop 31, the result is all ones.
- R6: With `op_sel` = 1 the result is `(src_s & src_b) | (src_a & ~src_b)`.
- R7: `out_valid` is high in the cycle after a clock edge that samples `in_valid` high, and low after an edge that samples it low; `out_result` carries that operation's value in the same cycle.
- R8: While `in_valid` is low, `out_result` keeps its previous value.
- R9: During and right after reset, `out_valid` is 0 and `out_result` is 0.
- R10: With `op_sel` = 0, `src_a` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_sel | input | 1 | 0 = build range mask, 1 = masked merge |
| src_s | input | 32 | Start index (low bits) or merge source |
| src_b | input | 32 | Stop index (low bits) or merge mask |
| src_a | input | 32 | Merge destination (prior value) |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 32 | Registered result |

## Verification
The hardest cases to reach are the edges of the index arithmetic. One is stop = 31, where the second shift amount reaches 32 and must give zero. Another is the start = 0, stop = 31 pair, which sits on both the "full" rule and the non-wrapped rule. A third is the one-apart wrap, where the XOR term vanishes entirely. The stimulus sweeps all 1024 start/stop pairs back to back. It fills the upper bits of both index words and the unused destination word with changing junk, so these corners and the ignored bits are exercised in one pass. Idle gaps between bursts then show that the result register holds.

// File: rtl/mgi_pkg.sv
package mgi_pkg;

    typedef enum logic {
        MGI_OP_BUILD = 1'b0,
        MGI_OP_MERGE = 1'b1
    } mgi_op_e;

endpackage

// File: rtl/mgi_thermo.sv
// All-ones word shifted right (toward the LSB) by amt; amt may equal W,
// giving zero. MSB-first position g is one when g >= amt.
module mgi_thermo #(
    parameter int unsigned W   = 32,
    parameter int unsigned AMW = $clog2(W) + 1
) (
    input  logic [AMW-1:0] amt,
    output logic [W-1:0]   ones_shr
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign ones_shr[W-1-g] = (AMW'(g) >= amt);
    end

endmodule

// File: rtl/mgi_mask_gen.sv
module mgi_mask_gen #(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = $clog2(W)
) (
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    output logic [W-1:0]     mask
);

    localparam int unsigned AMW = IDX_W + 1;

    logic [AMW-1:0] first_amt;
    logic [AMW-1:0] past_last_amt;
    logic [W-1:0]   from_first;
    logic [W-1:0]   from_past_last;
    logic [W-1:0]   span;
    logic           wraps;
    logic           covers_all;

    assign first_amt     = {1'b0, first_idx};
    assign past_last_amt = {1'b0, last_idx} + AMW'(1);

    mgi_thermo #(.W(W), .AMW(AMW)) u_th_first (
        .amt      (first_amt),
        .ones_shr (from_first)
    );

    mgi_thermo #(.W(W), .AMW(AMW)) u_th_last (
        .amt      (past_last_amt),
        .ones_shr (from_past_last)
    );

    assign span       = from_first ^ from_past_last;
    assign wraps      = (last_idx < first_idx);
    assign covers_all = (first_idx == (last_idx + IDX_W'(1)));

    always_comb begin
        if (covers_all) begin
            mask = '1;
        end else if (wraps) begin
            mask = ~span;
        end else begin
            mask = span;
        end
    end

endmodule

// File: rtl/mgi_merge.sv
module mgi_merge #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] ins_word,
    input  logic [W-1:0] sel_mask,
    input  logic [W-1:0] keep_word,
    output logic [W-1:0] merged
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign merged[g] = sel_mask[g] ? ins_word[g] : keep_word[g];
    end

endmodule

// File: rtl/mgi_unit.sv
module mgi_unit
    import mgi_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sel,
    input  logic [DATA_W-1:0] src_s,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] src_a,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } stage_t;

    stage_t            stage_d;
    stage_t            stage_q;
    mgi_op_e           op_d;
    logic [DATA_W-1:0] range_mask;
    logic [DATA_W-1:0] merge_word;

    mgi_mask_gen #(.W(DATA_W), .IDX_W(IDX_W)) u_mask (
        .first_idx (src_s[IDX_W-1:0]),
        .last_idx  (src_b[IDX_W-1:0]),
        .mask      (range_mask)
    );

    mgi_merge #(.W(DATA_W)) u_merge (
        .ins_word  (src_s),
        .sel_mask  (src_b),
        .keep_word (src_a),
        .merged    (merge_word)
    );

    always_comb begin
        op_d        = mgi_op_e'(op_sel);
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = (op_d == MGI_OP_MERGE) ? merge_word : range_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.vld;
    assign out_result = stage_q.res;

endmodule

// File: rtl/mgi_unit_chk.sv
module mgi_unit_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              op_sel,
    input logic [DATA_W-1:0] src_s,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] src_a,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);

    localparam int unsigned IDX_W = $clog2(DATA_W);

    // R7
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result));

    // R3
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && (src_s[IDX_W-1:0] == src_b[IDX_W-1:0]))
        |=> ($countones(out_result) == 1));

    // R5
    full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel &&
         (src_s[IDX_W-1:0] == IDX_W'(src_b[IDX_W-1:0] + IDX_W'(1))))
        |=> (out_result == '1));

    // R4
    wrap_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_sel && (src_s[IDX_W-1:0] > src_b[IDX_W-1:0]))
        |=> (out_result[DATA_W-1] && out_result[0]));

    // R6
    merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel)
        |=> (((out_result ^ $past(src_a)) & ~$past(src_b)) == '0));

    // R6
    merge_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel)
        |=> (((out_result ^ $past(src_s)) & $past(src_b)) == '0));

endmodule

bind mgi_unit mgi_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sel     (op_sel),
    .src_s      (src_s),
    .src_b      (src_b),
    .src_a      (src_a),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/tb_mgi_unit.sv
module tb_mgi_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic [31:0] src_s = '0;
    logic [31:0] src_b = '0;
    logic [31:0] src_a = '0;
    logic        out_valid;
    logic [31:0] out_result;

    int unsigned checks = 0;
    int unsigned errors = 0;
    bit          started = 1'b0;
    logic [31:0] last_exp = '0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    mgi_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .src_s      (src_s),
        .src_b      (src_b),
        .src_a      (src_a),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    function automatic logic [31:0] ref_mask(int st, int sp);
        logic [31:0] m;
        for (int i = 0; i < 32; i++) begin
            if (st <= sp) m[31-i] = (i >= st) && (i <= sp);
            else          m[31-i] = (i >= st) || (i <= sp);
        end
        return m;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic op, logic [31:0] s, logic [31:0] b,
                         logic [31:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        src_s    = s;
        src_b    = b;
        src_a    = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        src_s    = $urandom;
        src_b    = $urandom;
        src_a    = $urandom;
        op_sel   = $urandom;
        repeat (n - 1) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && started) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R7: got out_valid=1 expected 0 (no pending item)");
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, out_result, e);
                    last_exp = e;
                end
            end else begin
                check("R8 hold while idle", out_result, last_exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R9 out_result in reset", out_result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 out_valid after reset", {31'b0, out_valid}, 32'h0);
        check("R9 out_result after reset", out_result, 32'h0);
        started = 1'b1;

        // exhaustive start/stop sweep, junk in upper bits and in src_a (R1, R10)
        for (int st = 0; st < 32; st++) begin
            for (int sp = 0; sp < 32; sp++) begin
                string tag;
                logic [31:0] s;
                logic [31:0] b;
                if ((st == ((sp + 1) % 32)))   tag = "R5 full mask R1 R10";
                else if (st == sp)             tag = "R3 single bit R1 R10";
                else if (st < sp)              tag = "R2 plain range R1 R10";
                else                           tag = "R4 wrapped range R1 R10";
                s = {$urandom} << 5 | 32'(st);
                b = {$urandom} << 5 | 32'(sp);
                issue(1'b0, s, b, $urandom, ref_mask(st, sp), tag);
            end
            if (st % 8 == 7) idle(3);
        end

        // merge patterns (R6)
        issue(1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1234_5678, 32'h1234_5678, "R6 empty mask");
        issue(1'b1, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h1234_5678, 32'hCAFE_F00D, "R6 full mask");
        issue(1'b1, 32'hAAAA_AAAA, 32'hFF00_FF00, 32'h5555_5555, 32'hAA55_AA55, "R6 byte mask");
        for (int k = 0; k < 64; k++) begin
            logic [31:0] s;
            logic [31:0] b;
            logic [31:0] a;
            s = $urandom;
            b = $urandom;
            a = $urandom;
            issue(1'b1, s, b, a, (s & b) | (a & ~b), "R6 random merge");
            if (k % 16 == 5) idle(2);
        end
        // alternate ops back to back (R7)
        issue(1'b0, 32'd4, 32'd7, 32'hFFFF_FFFF, 32'h0F00_0000, "R7 back-to-back build");
        issue(1'b1, 32'h0000_FFFF, 32'h00FF_00FF, 32'h0, 32'h0000_00FF, "R7 back-to-back merge");
        idle(4);
        check("R7 queue drained", 32'(exp_q.size()), 32'h0);
        check("R7 out_valid low when idle", {31'b0, out_valid}, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule